// File: doc/BRIEF.md
# Two-Level Interrupt Cause Aggregator

This block gathers interrupt sources into two 32-bit main-cause words and drives a set of level interrupt lines from them. The low word mirrors a vector of level sources presented on an input port. The high word carries summary bits. Four of them come from 32 general-purpose pin interrupt bits, taken in groups of eight under a pin mask. The others come from a serial-DMA cause register, one bit per channel.

Each interrupt output has its own low and high mask registers and its own read-only select-cause register. A select-cause read returns whichever main-cause word is masked-active for that output. Bit 30 of the result marks that the high word was chosen, and bit 31 marks that both words are masked-active. Software reaches every register through a flat 32-bit read/write port with word addresses and combinational read data. Pin bits are only set or cleared through dedicated set and clear addresses. Serial-DMA cause bits are written directly by software, and hardware event pulses can also raise them.

Top module: `irq_cause_hub`

## Requirements
- R1: A write to address 0x03 ORs the written bits into the pin word. A write to address 0x04 clears the written bits. The pin word reads back at address 0x02.
- R2: High-cause bit 24+g is set when pin bits 8g+7..8g AND the pin mask (address 0x05) are nonzero, for g = 0..3.
- R3: The serial-DMA cause register (address 0x06) holds a 4-bit field per channel, with channel n at bits 8n+3..8n. Under the DMA mask (address 0x07), any masked-active bit of channel n sets high-cause bit 4+2n, so bits 4 and 6 by default. A software write replaces the register. A pulse on dma_evt_i[4n+b] sets bit 8n+b.
- R4: The low main-cause word (address 0x00) follows lo_src_i. The high main-cause word (address 0x01) holds only summary bits. Both words are read-only, and writes to them are ignored.
- R5: irq_o[k] is high when (low cause AND low mask k) or (high cause AND high mask k) is nonzero. Low mask k is at address 0x10+4k, and high mask k is at 0x11+4k.
- R6: The select-cause word of output k (address 0x12+4k) returns high-cause bits 29:0 with bit 30 set when only the high word is masked-active. Otherwise it returns low-cause bits 29:0 with bit 30 clear.
- R7: Bit 31 of a select-cause word is set only when both the low and the high word are masked-active for that output.
- R8: Cause words and interrupt lines update one clock after the register write or source change that affects them.
- R9: Synchronous active-low reset clears the pin word, every mask, the DMA cause register and both cause words, and deasserts every interrupt line.
- R10: Each output uses only its own mask pair. A mask change on one output does not affect another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr; unmapped addresses read 0 |
| lo_src_i | input | 32 | Level sources for the low main-cause word |
| dma_evt_i | input | 4*DMA_CH | Serial-DMA event pulses, 4 per channel |
| irq_o | output | NUM_OUT | Level interrupt lines, one per output |

## Verification
The assertions assume reset is held low for at least one clock before any check that compares against a previous cycle. They also assume every input is settled by the rising edge, since the summary, interrupt and field checks look one edge back at the pin, mask and cause registers. The bench holds reset for several cycles and changes inputs only on the falling edge. It drives dma_evt_i as one-cycle pulses and moves lo_src_i only between reads, so every sampled value belongs to a single cycle.

// File: rtl/irq_hub_pkg.sv
// Package: register map and select-cause helper for the interrupt cause hub.
// Assumes 32-bit data and 8-bit word addresses.
package irq_hub_pkg;
    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_LO_CAUSE = 8'h00;
    localparam logic [AW-1:0] A_HI_CAUSE = 8'h01;
    localparam logic [AW-1:0] A_PIN_VAL  = 8'h02;
    localparam logic [AW-1:0] A_PIN_SET  = 8'h03;
    localparam logic [AW-1:0] A_PIN_CLR  = 8'h04;
    localparam logic [AW-1:0] A_PIN_MASK = 8'h05;
    localparam logic [AW-1:0] A_DMA_CAUSE = 8'h06;
    localparam logic [AW-1:0] A_DMA_MASK = 8'h07;
    localparam logic [AW-1:0] A_OUT_BASE = 8'h10;
    localparam int OUT_STRIDE = 4;

    localparam int HI_GRP_BASE = 24;
    localparam int HI_DMA_BASE = 4;
    localparam int HI_DMA_STEP = 2;

    // Picks the cause word that a select-cause read reports.
    function automatic logic [DW-1:0] sel_word(input logic [DW-1:0] lo,
                                               input logic [DW-1:0] hi,
                                               input logic [DW-1:0] mlo,
                                               input logic [DW-1:0] mhi);
        logic lo_act;
        logic hi_act;
        lo_act = |(lo & mlo);
        hi_act = |(hi & mhi);
        if (!lo_act && hi_act)
            sel_word = {1'b0, 1'b1, hi[29:0]};
        else
            sel_word = {lo_act && hi_act, 1'b0, lo[29:0]};
    endfunction
endpackage

// File: rtl/irq_pin_bank.sv
// Pin interrupt bank: holds the pin word, updated by set and clear strobes,
// and the pin mask. It produces one combinational hit per group of pins.
// Assumes PIN_W is a multiple of GROUPS.
module irq_pin_bank #(
    parameter int PIN_W  = 32,
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              mask_we,
    input  logic [PIN_W-1:0]  wdata,
    output logic [PIN_W-1:0]  pin_q,
    output logic [PIN_W-1:0]  pmask_q,
    output logic [GROUPS-1:0] grp_hit
);
    localparam int GW = PIN_W / GROUPS;

    // Pin word: set ORs bits in, clear removes bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= '0;
        else if (set_we)
            pin_q <= pin_q | wdata;
        else if (clr_we)
            pin_q <= pin_q & ~wdata;
    end

    // Pin mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pmask_q <= '0;
        else if (mask_we)
            pmask_q <= wdata;
    end

    // One masked-active summary per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_hit[g] = |(pin_q[g*GW +: GW] & pmask_q[g*GW +: GW]);
    end
endmodule

// File: rtl/irq_dma_bank.sv
// Serial-DMA cause bank: the cause register holds one FIELD_W field per
// channel at a stride of FIELD_STRIDE bits. Software writes replace the
// register and event pulses OR into it. It produces one masked hit per
// channel. Assumes DMA_CH*FIELD_STRIDE <= 32.
module irq_dma_bank #(
    parameter int DMA_CH       = 2,
    parameter int FIELD_W      = 4,
    parameter int FIELD_STRIDE = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cause_we,
    input  logic                      mask_we,
    input  logic [31:0]               wdata,
    input  logic [DMA_CH*FIELD_W-1:0] evt,
    output logic [31:0]               cause_q,
    output logic [31:0]               mask_q,
    output logic [DMA_CH-1:0]         ch_hit
);
    logic [31:0] evt_word;

    // Spread the packed event pulses onto their field positions.
    always_comb begin
        evt_word = '0;
        for (int c = 0; c < DMA_CH; c++)
            for (int b = 0; b < FIELD_W; b++)
                evt_word[c*FIELD_STRIDE + b] = evt[c*FIELD_W + b];
    end

    // Cause register: a write replaces the value, same-cycle events are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else
            cause_q <= (cause_we ? wdata : cause_q) | evt_word;
    end

    // DMA mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= wdata;
    end

    // Per-channel masked-active summary.
    for (genvar c = 0; c < DMA_CH; c++) begin : g_ch
        assign ch_hit[c] = |(cause_q[c*FIELD_STRIDE +: FIELD_W] &
                             mask_q[c*FIELD_STRIDE +: FIELD_W]);
    end
endmodule

// File: rtl/irq_out_ctrl.sv
// One interrupt output: its low and high mask registers, the registered
// level line and the select-cause word. The line is computed from the
// next-state cause words, so it lines up with the registered causes.
module irq_out_ctrl
    import irq_hub_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mlo_we,
    input  logic          mhi_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] lo_d,
    input  logic [DW-1:0] hi_d,
    input  logic [DW-1:0] lo_q,
    input  logic [DW-1:0] hi_q,
    output logic          irq_q,
    output logic [DW-1:0] mlo_q,
    output logic [DW-1:0] mhi_q,
    output logic [DW-1:0] sel
);
    // Mask pair for this output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mlo_q <= '0;
            mhi_q <= '0;
        end else begin
            if (mlo_we) mlo_q <= wdata;
            if (mhi_we) mhi_q <= wdata;
        end
    end

    // Level interrupt line, registered alongside the cause words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= (|(lo_d & mlo_q)) || (|(hi_d & mhi_q));
    end

    // Select-cause word from the registered cause words.
    assign sel = sel_word(lo_q, hi_q, mlo_q, mhi_q);
endmodule

// File: rtl/irq_cause_hub.sv
// Top of the interrupt cause hub. It decodes the register port, builds the
// high cause from the pin-group and DMA-channel summaries, registers both
// cause words and instantiates one output controller per interrupt line.
// Assumes DMA_CH <= 4 so every DMA field fits the 32-bit cause register.
module irq_cause_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_OUT    = 4,
    parameter int DMA_CH     = 2,
    parameter int PIN_GROUPS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [DW-1:0]       lo_src_i,
    input  logic [DMA_CH*4-1:0] dma_evt_i,
    output logic [NUM_OUT-1:0]  irq_o
);
    localparam int FIELD_W = 4;
    localparam int FIELD_STRIDE = 8;

    logic [DW-1:0] pin_q, pmask_q, dma_q, dmask_q;
    logic [PIN_GROUPS-1:0] grp_hit;
    logic [DMA_CH-1:0] ch_hit;
    logic [DW-1:0] lo_d, hi_d, lo_q, hi_q;
    logic [NUM_OUT-1:0][DW-1:0] mlo_all, mhi_all, sel_all;

    irq_pin_bank #(.PIN_W(DW), .GROUPS(PIN_GROUPS)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .set_we(reg_wr && reg_addr == A_PIN_SET),
        .clr_we(reg_wr && reg_addr == A_PIN_CLR),
        .mask_we(reg_wr && reg_addr == A_PIN_MASK),
        .wdata(reg_wdata),
        .pin_q(pin_q), .pmask_q(pmask_q), .grp_hit(grp_hit)
    );

    irq_dma_bank #(.DMA_CH(DMA_CH), .FIELD_W(FIELD_W),
                   .FIELD_STRIDE(FIELD_STRIDE)) u_dma (
        .clk(clk), .rst_n(rst_n),
        .cause_we(reg_wr && reg_addr == A_DMA_CAUSE),
        .mask_we(reg_wr && reg_addr == A_DMA_MASK),
        .wdata(reg_wdata), .evt(dma_evt_i),
        .cause_q(dma_q), .mask_q(dmask_q), .ch_hit(ch_hit)
    );

    // Next-state cause words: sources for the low word, summaries for the high.
    always_comb begin
        lo_d = lo_src_i;
        hi_d = '0;
        for (int g = 0; g < PIN_GROUPS; g++)
            hi_d[HI_GRP_BASE + g] = grp_hit[g];
        for (int c = 0; c < DMA_CH; c++)
            hi_d[HI_DMA_BASE + HI_DMA_STEP*c] = ch_hit[c];
    end

    // Main-cause registers; no write path reaches them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam logic [AW-1:0] BASE = AW'(A_OUT_BASE + OUT_STRIDE*k);
        irq_out_ctrl u_ctrl (
            .clk(clk), .rst_n(rst_n),
            .mlo_we(reg_wr && reg_addr == BASE),
            .mhi_we(reg_wr && reg_addr == BASE + AW'(1)),
            .wdata(reg_wdata),
            .lo_d(lo_d), .hi_d(hi_d), .lo_q(lo_q), .hi_q(hi_q),
            .irq_q(irq_o[k]),
            .mlo_q(mlo_all[k]), .mhi_q(mhi_all[k]), .sel(sel_all[k])
        );
    end

    // Combinational read mux; unmapped and write-only addresses read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LO_CAUSE:  reg_rdata = lo_q;
            A_HI_CAUSE:  reg_rdata = hi_q;
            A_PIN_VAL:   reg_rdata = pin_q;
            A_PIN_MASK:  reg_rdata = pmask_q;
            A_DMA_CAUSE: reg_rdata = dma_q;
            A_DMA_MASK:  reg_rdata = dmask_q;
            default:     reg_rdata = '0;
        endcase
        for (int k = 0; k < NUM_OUT; k++) begin
            if (reg_addr == AW'(A_OUT_BASE + OUT_STRIDE*k))     reg_rdata = mlo_all[k];
            if (reg_addr == AW'(A_OUT_BASE + OUT_STRIDE*k + 1)) reg_rdata = mhi_all[k];
            if (reg_addr == AW'(A_OUT_BASE + OUT_STRIDE*k + 2)) reg_rdata = sel_all[k];
        end
    end
endmodule

// File: rtl/irq_hub_chk.sv
// Checker for the interrupt cause hub, attached by bind. It relates the
// registered cause words, masks, select words and lines across one edge.
// Assumes reset is held low for at least one clock at start.
module irq_hub_chk #(
    parameter int NUM_OUT    = 4,
    parameter int DMA_CH     = 2,
    parameter int PIN_GROUPS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_OUT-1:0]      irq_o,
    input logic [31:0]             lo_q,
    input logic [31:0]             hi_q,
    input logic [31:0]             pin_q,
    input logic [31:0]             pmask_q,
    input logic [31:0]             dma_q,
    input logic [DMA_CH*4-1:0]     dma_evt_i,
    input logic [NUM_OUT-1:0][31:0] mlo_all,
    input logic [NUM_OUT-1:0][31:0] mhi_all,
    input logic [NUM_OUT-1:0][31:0] sel_all
);
    localparam int GW = 32 / PIN_GROUPS;

    function automatic logic [31:0] summary_bits();
        logic [31:0] m;
        m = '0;
        for (int g = 0; g < PIN_GROUPS; g++) m[24 + g] = 1'b1;
        for (int c = 0; c < DMA_CH; c++) m[4 + 2*c] = 1'b1;
        return m;
    endfunction
    localparam logic [31:0] SUM_BITS = summary_bits();

    // R4: the high word carries nothing but summary bits.
    assert_hi_only_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q & ~SUM_BITS) == 32'h0);

    for (genvar g = 0; g < PIN_GROUPS; g++) begin : g_grp
        // R2: group summary follows the masked pins one edge later.
        assert_grp_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> hi_q[24 + g] ==
                $past(|(pin_q[g*GW +: GW] & pmask_q[g*GW +: GW])));
    end

    for (genvar j = 0; j < DMA_CH*4; j++) begin : g_evt
        // R3: an event pulse lands in its field bit.
        assert_dma_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dma_evt_i[j])) |-> dma_q[(j/4)*8 + (j%4)]);
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        // R5, R8: line equals registered causes against the masks of the prior cycle.
        assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> irq_o[k] ==
                ((|(lo_q & $past(mlo_all[k]))) || (|(hi_q & $past(mhi_all[k])))));
        // R6: a high-tagged select word carries high-cause bits.
        assert_sel_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sel_all[k][30] |-> sel_all[k][29:0] == hi_q[29:0]);
        // R7: the both-active flag never goes with the high tag.
        assert_sel_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sel_all[k][31] |-> (!sel_all[k][30] && sel_all[k][29:0] == lo_q[29:0]));
        // R9: first cycle after reset has every line low.
        assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> !irq_o[k]);
    end
endmodule

bind irq_cause_hub irq_hub_chk #(
    .NUM_OUT(NUM_OUT), .DMA_CH(DMA_CH), .PIN_GROUPS(PIN_GROUPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o),
    .lo_q(lo_q), .hi_q(hi_q), .pin_q(pin_q), .pmask_q(pmask_q),
    .dma_q(dma_q), .dma_evt_i(dma_evt_i),
    .mlo_all(mlo_all), .mhi_all(mhi_all), .sel_all(sel_all)
);

// File: tb/sim_irq_cause_hub.sv
`timescale 1ns/1ps
// Bench for irq_cause_hub: a vector table walked by one loop, then
// directed tests for reset, latency, select-cause and read-only cases.
module sim_irq_cause_hub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lo_src_i = '0;
    logic [7:0]  dma_evt_i = '0;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    irq_cause_hub u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_src_i(lo_src_i),
        .dma_evt_i(dma_evt_i), .irq_o(irq_o)
    );

    // Vector table: pins, pin mask, DMA cause, DMA mask, output-0 high mask,
    // expected high cause, expected irq_o[0].
    localparam logic [31:0] VPIN [6] = '{32'h0000_0001, 32'h0000_0100, 32'h8001_0000,
                                         32'h0, 32'h0, 32'h00FF_0000};
    localparam logic [31:0] VPM  [6] = '{32'h0000_00FF, 32'h0000_00FF, 32'hFFFF_FFFF,
                                         32'h0, 32'h0, 32'h0001_0000};
    localparam logic [31:0] VDC  [6] = '{32'h0, 32'h0, 32'h0, 32'h0000_0002,
                                         32'h0000_0400, 32'h0000_0F0F};
    localparam logic [31:0] VDM  [6] = '{32'h0, 32'h0, 32'h0, 32'h0000_000F,
                                         32'h0000_0F00, 32'h0000_0100};
    localparam logic [31:0] VOM  [6] = '{32'h0100_0000, 32'hFFFF_FFFF, 32'h0400_0000,
                                         32'h0000_0040, 32'h0000_0040, 32'h0000_0010};
    localparam logic [31:0] VHI  [6] = '{32'h0100_0000, 32'h0, 32'h0C00_0000,
                                         32'h0000_0010, 32'h0000_0040, 32'h0400_0040};
    localparam bit          VIRQ [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R9: reset state
        chk("R9 irq after reset", 32'(irq_o), 32'h0);
        rd(8'h01, rv); chk("R9 hi cause", rv, 32'h0);
        rd(8'h02, rv); chk("R9 pin word", rv, 32'h0);
        rd(8'h06, rv); chk("R9 dma cause", rv, 32'h0);

        // R2 R3 R5: vector table
        for (int i = 0; i < 6; i++) begin
            wr(8'h04, 32'hFFFF_FFFF);
            wr(8'h03, VPIN[i]);
            wr(8'h05, VPM[i]);
            wr(8'h06, VDC[i]);
            wr(8'h07, VDM[i]);
            wr(8'h11, VOM[i]);
            settle();
            rd(8'h01, rv); chk($sformatf("R2/R3 hi cause vec %0d", i), rv, VHI[i]);
            chk($sformatf("R5 irq0 vec %0d", i), 32'(irq_o[0]), 32'(VIRQ[i]));
            rd(8'h06, rv); chk($sformatf("R3 dma replace vec %0d", i), rv, VDC[i]);
        end

        // R1: set ORs, clear removes
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h03, 32'h0000_00F0);
        wr(8'h03, 32'h0000_000F);
        rd(8'h02, rv); chk("R1 set ORs", rv, 32'h0000_00FF);
        wr(8'h04, 32'h0000_003C);
        rd(8'h02, rv); chk("R1 clear", rv, 32'h0000_00C3);

        // R8: one-clock latency of the low word and line
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h06, 32'h0);
        wr(8'h14, 32'h0000_0001);
        settle();
        lo_src_i = 32'h4000_0001;
        rd(8'h00, rv); chk("R8 lo before edge", rv, 32'h0);
        chk("R8 irq1 before edge", 32'(irq_o[1]), 32'h0);
        settle();
        rd(8'h00, rv); chk("R8 R4 lo after edge", rv, 32'h4000_0001);
        chk("R8 irq1 after edge", 32'(irq_o[1]), 32'h1);

        // R6 R7 R10: select cause on output 1
        wr(8'h05, 32'h0000_00FF);
        wr(8'h03, 32'h0000_0001);
        wr(8'h15, 32'h0100_0000);
        settle();
        rd(8'h16, rv); chk("R7 both active", rv, 32'h8000_0001);
        chk("R10 irq2 own masks", 32'(irq_o[2]), 32'h0);
        rd(8'h18, rv); chk("R10 mask lo of out2", rv, 32'h0);
        lo_src_i = 32'h0;
        settle();
        rd(8'h16, rv); chk("R6 high only", rv, 32'h4100_0000);
        wr(8'h04, 32'hFFFF_FFFF);
        lo_src_i = 32'h0000_0002;
        settle();
        rd(8'h16, rv); chk("R6 none active gives low", rv, 32'h0000_0002);
        chk("R5 irq1 off", 32'(irq_o[1]), 32'h0);

        // R4: cause words ignore writes
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        settle();
        rd(8'h01, rv); chk("R4 hi read-only", rv, 32'h0);
        rd(8'h00, rv); chk("R4 lo read-only", rv, 32'h0000_0002);

        // R3: event pulse on channel 1 bit 1
        wr(8'h07, 32'h0000_0F00);
        @(negedge clk); dma_evt_i = 8'h20;
        @(negedge clk); dma_evt_i = 8'h00;
        rd(8'h06, rv); chk("R3 event sets field", rv, 32'h0000_0200);
        settle();
        rd(8'h01, rv); chk("R3 ch1 summary bit6", rv, 32'h0000_0040);

        // R9: reset in mid-run
        wr(8'h03, 32'h0000_00FF);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R9 irq after re-reset", 32'(irq_o), 32'h0);
        rd(8'h02, rv); chk("R9 pins cleared", rv, 32'h0);
        rd(8'h14, rv); chk("R9 mask cleared", rv, 32'h0);
        rd(8'h06, rv); chk("R9 dma cleared", rv, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule